// File: doc/BRIEF.md
# Multi-band chroma key substitutor

This block sits in a pixel pipeline after the colour-space conversion stage. Every valid pixel arrives with its hue, saturation and lightness alongside its original RGB value. The block tests the pixel against a set of independently configured key bands. Each band has an enable, an inclusive saturation window, an inclusive luma window, and a hue window. The hue window is a signed centre with a symmetric tolerance, measured around the colour circle.

When a pixel falls inside an enabled band, its RGB is replaced by that band's solid replacement colour. If several bands accept the pixel, the lowest-numbered band decides the colour and the later bands leave it untouched. Pixels that no band accepts leave the block with their RGB unchanged.

The output carries the same valid pattern as the input, delayed by a fixed two-cycle pipeline. Band settings are plain input ports, held steady by the surrounding control logic while pixels flow.

Top module: `ck_keyer`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly two clock cycles. The RGB result for a pixel appears on `out_rgb` in the same cycle as its `out_valid`.
- R2: A band whose bit in `band_en` is 0 never affects a pixel, even when all of its windows contain that pixel.
- R3: The saturation test passes when `band_sat_lo <= in_sat <= band_sat_hi`. Both limits are inclusive. Band i uses bits [8i+7:8i] of each limit vector.
- R4: The luma test passes when `band_luma_lo <= in_luma <= band_luma_hi`. Both limits are inclusive. The limit vectors are packed the same way as in R3.
- R5: Hue values and centres are 14-bit two's complement numbers, and the full circle spans 16384 codes. The hue test passes when the shorter circular distance between the pixel hue and the band centre is at most the band's 13-bit unsigned tolerance. Band i uses centre bits [14i+13:14i] and tolerance bits [13i+12:13i]. A tolerance of 8191 excludes only the exactly opposite hue.
- R6: Hue windows wrap across the ±180° seam. For example, a centre of 8000 with a tolerance of 400 accepts -8192 and -7984, and rejects -7983.
- R7: A band accepts a pixel only when its hue, saturation and luma tests all pass.
- R8: When more than one enabled band accepts a pixel, the band with the lowest index supplies the colour.
- R9: An accepted pixel takes its band's colour from `band_rgb` bits [24i+23:24i]. Within each 24-bit colour, red is in [23:16], green in [15:8] and blue in [7:0]. A pixel that no band accepts leaves with its `in_rgb` unchanged.
- R10: After reset, `out_valid` is 0 and `out_rgb` is 0. `out_rgb` holds its last value in every cycle where `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| band_en | input | 4 | Per-band enable, bit i for band i |
| band_sat_lo | input | 32 | Per-band minimum saturation, 8 bits per band |
| band_sat_hi | input | 32 | Per-band maximum saturation, 8 bits per band |
| band_luma_lo | input | 32 | Per-band minimum luma, 8 bits per band |
| band_luma_hi | input | 32 | Per-band maximum luma, 8 bits per band |
| band_hue_ctr | input | 56 | Per-band signed hue centre, 14 bits per band |
| band_hue_tol | input | 52 | Per-band unsigned hue tolerance, 13 bits per band |
| band_rgb | input | 96 | Per-band replacement colour, 24 bits per band |
| in_valid | input | 1 | Input pixel qualifier |
| in_hue | input | 14 | Pixel hue, two's complement |
| in_sat | input | 8 | Pixel saturation |
| in_luma | input | 8 | Pixel lightness |
| in_rgb | input | 24 | Pixel original colour |
| out_valid | output | 1 | Output pixel qualifier |
| out_rgb | output | 24 | Output colour, substituted or passed through |

## Verification
The hardest cases to reach are the hue window edges at the ±180° seam. There, the circular distance must wrap through the 14-bit code space instead of being taken as a plain difference. The stimulus reaches them by placing one band's centre near +180° and sending hues one code inside and one code outside each wrapped edge, including -8192 itself. A second hard case is two bands accepting the same pixel. An overlapping pair of bands, with the lower one narrower in saturation and hue, separates "band 0 wins" from "band 3 wins" at every limit. A later reconfiguration with the widest tolerance probes the exactly opposite hue.

// File: rtl/ck_pkg.sv
package ck_pkg;
  localparam int CK_NUM_BANDS = 4;
  localparam int CK_HUE_W     = 14;
  localparam int CK_TOL_W     = 13;
  localparam int CK_CH_W      = 8;
  localparam int CK_RGB_W     = 3 * CK_CH_W;
  localparam int CK_SYNC_DEPTH = 2;
endpackage

// File: rtl/ck_rst_sync.sv
module ck_rst_sync #(
  parameter int DEPTH = ck_pkg::CK_SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[DEPTH-1];
endmodule

// File: rtl/ck_band_match.sv
module ck_band_match #(
  parameter int HUE_W = ck_pkg::CK_HUE_W,
  parameter int TOL_W = ck_pkg::CK_TOL_W,
  parameter int CH_W  = ck_pkg::CK_CH_W
) (
  input  logic             en,
  input  logic [CH_W-1:0]  sat_lo,
  input  logic [CH_W-1:0]  sat_hi,
  input  logic [CH_W-1:0]  luma_lo,
  input  logic [CH_W-1:0]  luma_hi,
  input  logic [HUE_W-1:0] hue_ctr,
  input  logic [TOL_W-1:0] hue_tol,
  input  logic [HUE_W-1:0] px_hue,
  input  logic [CH_W-1:0]  px_sat,
  input  logic [CH_W-1:0]  px_luma,
  output logic             hit
);
  localparam int DIST_W = HUE_W + 1;

  logic [HUE_W-1:0]  hue_diff;
  logic [DIST_W-1:0] hue_dist;
  logic [DIST_W-1:0] tol_ext;
  logic              hue_ok;
  logic              sat_ok;
  logic              luma_ok;

  always_comb begin
    // modular difference: the code space is exactly one full circle
    hue_diff = px_hue - hue_ctr;
    if (hue_diff[HUE_W-1]) hue_dist = {1'b0, ~hue_diff} + DIST_W'(1);
    else                   hue_dist = {1'b0, hue_diff};
    tol_ext  = DIST_W'(hue_tol);
    hue_ok   = (hue_dist <= tol_ext);
    sat_ok   = (px_sat  >= sat_lo)  && (px_sat  <= sat_hi);
    luma_ok  = (px_luma >= luma_lo) && (px_luma <= luma_hi);
    hit      = en && hue_ok && sat_ok && luma_ok;
  end
endmodule

// File: rtl/ck_prio_sel.sv
module ck_prio_sel #(
  parameter int NUM   = ck_pkg::CK_NUM_BANDS,
  parameter int RGB_W = ck_pkg::CK_RGB_W
) (
  input  logic [NUM-1:0]       match,
  input  logic [NUM*RGB_W-1:0] band_rgb,
  input  logic [RGB_W-1:0]     px_rgb,
  output logic [NUM-1:0]       grant,
  output logic [RGB_W-1:0]     rgb_o
);
  logic             found;
  logic [RGB_W-1:0] pick;

  always_comb begin
    grant = '0;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < NUM; i++) begin
      if (match[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
        pick     = band_rgb[i*RGB_W +: RGB_W];
      end
    end
    rgb_o = found ? pick : px_rgb;
  end

  // R8: at most one band owns a pixel, and only a band that accepted it
  always_comb begin
    p_grant_onehot_r8: assert ($onehot0(grant));
    p_grant_in_match_r8: assert ((grant & ~match) == '0);
  end
endmodule

// File: rtl/ck_keyer.sv
module ck_keyer #(
  parameter int NUM_BANDS = ck_pkg::CK_NUM_BANDS,
  parameter int HUE_W     = ck_pkg::CK_HUE_W,
  parameter int TOL_W     = ck_pkg::CK_TOL_W,
  parameter int CH_W      = ck_pkg::CK_CH_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_BANDS-1:0]         band_en,
  input  logic [NUM_BANDS*CH_W-1:0]    band_sat_lo,
  input  logic [NUM_BANDS*CH_W-1:0]    band_sat_hi,
  input  logic [NUM_BANDS*CH_W-1:0]    band_luma_lo,
  input  logic [NUM_BANDS*CH_W-1:0]    band_luma_hi,
  input  logic [NUM_BANDS*HUE_W-1:0]   band_hue_ctr,
  input  logic [NUM_BANDS*TOL_W-1:0]   band_hue_tol,
  input  logic [NUM_BANDS*3*CH_W-1:0]  band_rgb,
  input  logic                         in_valid,
  input  logic [HUE_W-1:0]             in_hue,
  input  logic [CH_W-1:0]              in_sat,
  input  logic [CH_W-1:0]              in_luma,
  input  logic [3*CH_W-1:0]            in_rgb,
  output logic                         out_valid,
  output logic [3*CH_W-1:0]            out_rgb
);
  localparam int RGB_W = 3 * CH_W;

  logic rst_q_n;

  ck_rst_sync #(.DEPTH(ck_pkg::CK_SYNC_DEPTH)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  // ---------------- stage 1: per-band comparisons ----------------
  logic [NUM_BANDS-1:0] hit_d;
  logic [NUM_BANDS-1:0] s1_hit;
  logic [RGB_W-1:0]     s1_rgb;
  logic                 s1_valid;
  logic                 s1_en;

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
    ck_band_match #(.HUE_W(HUE_W), .TOL_W(TOL_W), .CH_W(CH_W)) u_match (
      .en      (band_en[b]),
      .sat_lo  (band_sat_lo [b*CH_W  +: CH_W]),
      .sat_hi  (band_sat_hi [b*CH_W  +: CH_W]),
      .luma_lo (band_luma_lo[b*CH_W  +: CH_W]),
      .luma_hi (band_luma_hi[b*CH_W  +: CH_W]),
      .hue_ctr (band_hue_ctr[b*HUE_W +: HUE_W]),
      .hue_tol (band_hue_tol[b*TOL_W +: TOL_W]),
      .px_hue  (in_hue),
      .px_sat  (in_sat),
      .px_luma (in_luma),
      .hit     (hit_d[b])
    );
  end

  always_comb begin
    s1_en = in_valid;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      s1_valid <= 1'b0;
      s1_hit   <= '0;
      s1_rgb   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (s1_en) begin
        s1_hit <= hit_d;
        s1_rgb <= in_rgb;
      end
    end
  end

  // ---------------- stage 2: priority and substitution ----------------
  logic [NUM_BANDS-1:0] grant;
  logic [RGB_W-1:0]     sel_rgb;
  logic                 s2_en;

  ck_prio_sel #(.NUM(NUM_BANDS), .RGB_W(RGB_W)) u_sel (
    .match    (s1_hit),
    .band_rgb (band_rgb),
    .px_rgb   (s1_rgb),
    .grant    (grant),
    .rgb_o    (sel_rgb)
  );

  always_comb begin
    s2_en = s1_valid;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s2_en) out_rgb <= sel_rgb;
    end
  end

  // ---------------- assertions ----------------
  logic chk_live;
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) chk_live <= 1'b0;
    else          chk_live <= 1'b1;
  end

  p_s1_valid_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    chk_live |-> (s1_valid == $past(in_valid)));

  p_out_valid_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    chk_live |-> (out_valid == $past(s1_valid)));

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_chk
    p_disabled_band_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
      (chk_live && $past(in_valid && !band_en[b])) |-> !s1_hit[b]);
  end

  p_band0_wins_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (s1_valid && s1_hit[0]) |=> (out_rgb == $past(band_rgb[RGB_W-1:0])));

  p_pass_through_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (s1_valid && (s1_hit == '0)) |=> (out_rgb == $past(s1_rgb)));

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !s1_valid |=> $stable(out_rgb));
endmodule

// File: tb/ck_keyer_test.sv
`timescale 1ns/1ps
module ck_keyer_test;
  localparam int NB = 4;
  localparam int HW = 14;
  localparam int TW = 13;
  localparam int CW = 8;
  localparam int RW = 24;

  typedef struct packed {
    logic          vld;
    logic [HW-1:0] hue;
    logic [CW-1:0] sat;
    logic [CW-1:0] luma;
    logic [RW-1:0] rgb;
    logic [RW-1:0] exp;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1,  14'sd0,    8'd150, 8'd100, 24'hA0B000, 24'h00FF00, 4'd8}, // R8 band0 over band3
    '{1'b1,  14'sd0,    8'd50,  8'd100, 24'hA0B001, 24'h123456, 4'd7}, // R7 sat fails band0
    '{1'b1,  14'sd500,  8'd100, 8'd150, 24'hA0B002, 24'h00FF00, 4'd5}, // R5 R3 R4 inclusive edges
    '{1'b1,  14'sd501,  8'd150, 8'd100, 24'hA0B003, 24'h123456, 4'd5}, // R5 just outside
    '{1'b1, -14'sd500,  8'd200, 8'd50,  24'hA0B004, 24'h00FF00, 4'd3}, // R3 upper sat edge
    '{1'b1, -14'sd501,  8'd150, 8'd100, 24'hA0B005, 24'h123456, 4'd5}, // R5 negative side
    '{1'b1,  14'sd0,    8'd201, 8'd100, 24'hA0B006, 24'h123456, 4'd3}, // R3 above max
    '{1'b1,  14'sd0,    8'd150, 8'd49,  24'hA0B007, 24'h123456, 4'd4}, // R4 below min
    '{1'b1,  14'sd0,    8'd150, 8'd151, 24'hA0B008, 24'h123456, 4'd4}, // R4 above max
    '{1'b1,  14'sd1000, 8'd0,   8'd0,   24'hA0B009, 24'h123456, 4'd9}, // R9 band3 colour
    '{1'b1,  14'sd1001, 8'd0,   8'd0,   24'hA0B00A, 24'hA0B00A, 4'd2}, // R2 band2 off, pass
    '{1'b0,  14'sd0,    8'd150, 8'd100, 24'h555555, 24'hA0B00A, 4'd10},// R10 bubble holds
    '{1'b1, -14'sd8192, 8'd10,  8'd10,  24'hA0B00C, 24'h0000FF, 4'd6}, // R6 seam
    '{1'b1, -14'sd7984, 8'd10,  8'd10,  24'hA0B00D, 24'h0000FF, 4'd6}, // R6 wrapped edge
    '{1'b1, -14'sd7983, 8'd10,  8'd10,  24'hA0B00E, 24'hA0B00E, 4'd6}, // R6 outside
    '{1'b1,  14'sd7600, 8'd10,  8'd10,  24'hA0B00F, 24'h0000FF, 4'd6}, // R6 near edge
    '{1'b1,  14'sd7599, 8'd10,  8'd10,  24'hA0B010, 24'hA0B010, 4'd6}, // R6 outside
    '{1'b1,  14'sd4000, 8'd255, 8'd255, 24'hA0B011, 24'hA0B011, 4'd9}  // R9 no band
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NB-1:0]     band_en;
  logic [NB*CW-1:0]  band_sat_lo, band_sat_hi, band_luma_lo, band_luma_hi;
  logic [NB*HW-1:0]  band_hue_ctr;
  logic [NB*TW-1:0]  band_hue_tol;
  logic [NB*RW-1:0]  band_rgb;
  logic              in_valid;
  logic [HW-1:0]     in_hue;
  logic [CW-1:0]     in_sat, in_luma;
  logic [RW-1:0]     in_rgb;
  logic              out_valid;
  logic [RW-1:0]     out_rgb;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  ck_keyer uut (
    .clk(clk), .rst_n(rst_n), .band_en(band_en),
    .band_sat_lo(band_sat_lo), .band_sat_hi(band_sat_hi),
    .band_luma_lo(band_luma_lo), .band_luma_hi(band_luma_hi),
    .band_hue_ctr(band_hue_ctr), .band_hue_tol(band_hue_tol),
    .band_rgb(band_rgb), .in_valid(in_valid), .in_hue(in_hue),
    .in_sat(in_sat), .in_luma(in_luma), .in_rgb(in_rgb),
    .out_valid(out_valid), .out_rgb(out_rgb)
  );

  task automatic check(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_band(input int b, input logic [HW-1:0] ctr, input logic [TW-1:0] tol,
                          input logic [CW-1:0] slo, input logic [CW-1:0] shi,
                          input logic [CW-1:0] llo, input logic [CW-1:0] lhi,
                          input logic [RW-1:0] col);
    band_hue_ctr[b*HW +: HW] = ctr;
    band_hue_tol[b*TW +: TW] = tol;
    band_sat_lo [b*CW +: CW] = slo;
    band_sat_hi [b*CW +: CW] = shi;
    band_luma_lo[b*CW +: CW] = llo;
    band_luma_hi[b*CW +: CW] = lhi;
    band_rgb    [b*RW +: RW] = col;
  endtask

  task automatic idle();
    in_valid = 1'b0; in_hue = '0; in_sat = '0; in_luma = '0; in_rgb = '0;
  endtask

  task automatic send_one(input string tag, input logic [HW-1:0] h, input logic [CW-1:0] s,
                          input logic [CW-1:0] l, input logic [RW-1:0] c, input logic [RW-1:0] e);
    @(negedge clk);
    in_valid = 1'b1; in_hue = h; in_sat = s; in_luma = l; in_rgb = c;
    @(negedge clk);
    idle();
    @(negedge clk);
    check({tag, " valid R1"}, RW'(out_valid), RW'(1));
    check(tag, out_rgb, e);
    @(negedge clk);
    check({tag, " idle R1"}, RW'(out_valid), RW'(0));
    check({tag, " hold R10"}, out_rgb, e);
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL R1 watchdog actual=timeout expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle();
    band_en = 4'b1011;
    set_band(0, 14'sd0,    13'd500,  8'd100, 8'd200, 8'd50, 8'd150, 24'h00FF00);
    set_band(1, 14'sd8000, 13'd400,  8'd0,   8'd255, 8'd0,  8'd255, 24'h0000FF);
    set_band(2, 14'sd0,    13'd8191, 8'd0,   8'd255, 8'd0,  8'd255, 24'hFF0000);
    set_band(3, 14'sd0,    13'd1000, 8'd0,   8'd255, 8'd0,  8'd255, 24'h123456);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state
    check("reset valid R10", RW'(out_valid), RW'(0));
    check("reset rgb R10", out_rgb, '0);

    // streamed vector table, one pixel per cycle, result two cycles later
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check($sformatf("vec%0d valid R1/R%0d", i - 2, VECS[i-2].req),
              RW'(out_valid), RW'(VECS[i-2].vld));
        check($sformatf("vec%0d rgb R%0d", i - 2, VECS[i-2].req),
              out_rgb, VECS[i-2].exp);
      end
      if (i < NV) begin
        in_valid = VECS[i].vld; in_hue = VECS[i].hue; in_sat = VECS[i].sat;
        in_luma = VECS[i].luma; in_rgb = VECS[i].rgb;
      end else begin
        idle();
      end
    end
    @(negedge clk);
    check("drain valid R1", RW'(out_valid), RW'(0));
    check("drain hold R10", out_rgb, 24'hA0B011);

    // R5: widest tolerance, only the exactly opposite hue is excluded
    band_en = 4'b0001;
    set_band(0, 14'sd0, 13'd8191, 8'd0, 8'd255, 8'd0, 8'd255, 24'h00FF00);
    send_one("tol max near R5", 14'sd8191, 8'd7, 8'd7, 24'h111111, 24'h00FF00);
    send_one("tol max opposite R5", -14'sd8192, 8'd7, 8'd7, 24'h222222, 24'h222222);

    // R2: every band off, a pixel inside all windows passes unchanged
    band_en = 4'b0000;
    send_one("all off R2", 14'sd0, 8'd7, 8'd7, 24'h333333, 24'h333333);

    // R10: asynchronous reset in mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("mid reset valid R10", RW'(out_valid), RW'(0));
    check("mid reset rgb R10", out_rgb, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: band 3 alone accepts when band 0 is off; band 0 wins when back on
    band_en = 4'b1000;
    send_one("band3 alone R8", 14'sd0, 8'd150, 8'd100, 24'h444444, 24'h123456);
    band_en = 4'b1001;
    set_band(0, 14'sd0, 13'd500, 8'd100, 8'd200, 8'd50, 8'd150, 24'h00FF00);
    send_one("band0 first R8", 14'sd0, 8'd150, 8'd100, 24'h444444, 24'h00FF00);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule